// File: doc/BRIEF.md
# USB Host Endpoint-Zero Transaction Controller

This block is the control and status logic for endpoint 0 of a USB host. Software sees one 8-bit register. It sets request bits in that register to ask for a SETUP, OUT or IN transaction. The block turns those bits into token requests for a simplified packet engine, and each request carries the data-toggle value to use. The engine returns abstract outcomes: ACK, NAK, STALL, timeout, or data received. The block folds each outcome back into the register, keeps the data toggle, and raises a one-cycle endpoint-0 interrupt pulse.

The block does not store FIFO data, check CRC, signal on the bus, or generate frames. A start-of-frame tick comes in from outside. The NAK-duration limit is measured in these ticks.

Top module: `usb_ep0_host_ctrl`

## Requirements
- R1: After reset the register reads 0x00, no token is requested and the interrupt output is low. Register bits, from 7 down to 0, are: NAK halt, status stage, IN request, no-response error, setup select, stall seen, transmit ready, receive ready.
- R2: The token kind depends on the request bits. Transmit ready together with setup select issues a SETUP token (code 1). Transmit ready alone issues an OUT token (code 2). IN request alone issues an IN token (code 3). Transmit ready takes precedence over IN request.
- R3: A write with setup select set forces the toggle to 0. A write with the status-stage bit set forces the toggle to 1. If both are set, setup select wins.
- R4: An ACK to a SETUP or OUT token has three effects. It clears transmit ready and setup select. It inverts the toggle. It drives the interrupt high for exactly one cycle.
- R5: Data received for an IN token has four effects. It sets receive ready. It clears the IN request. It inverts the toggle. It pulses the interrupt.
- R6: The status-stage bit clears when a transaction issued while it is set completes, either by ACK or by data received.
- R7: Three consecutive timeouts set the no-response error bit, pulse the interrupt and drop all request bits. Any device response, including a NAK, restarts the count.
- R8: The NAK-duration counter counts start-of-frame ticks during a run of NAKs. When the count reaches a nonzero limit, the NAK halt bit is set. While that bit is set, no token is requested. A non-NAK outcome, or a write that sets a request bit, restarts the counter.
- R9: A STALL outcome sets stall seen and drops all request bits.
- R10: For the four status bits (NAK halt, error, stall seen, receive ready), writing 0 clears the bit and writing 1 leaves it unchanged. If a hardware set and a software clear happen in the same cycle, the bit ends up set.
- R11: Only one token is outstanding at a time, so a token request never stays high for two cycles in a row. An outcome that arrives while no token is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read value |
| nak_limit_i | input | NAK_W | NAK limit in start-of-frame ticks; 0 disables the limit |
| sof_i | input | 1 | Start-of-frame tick |
| tok_req_o | output | 1 | Token request. The engine accepts it in the same cycle |
| tok_kind_o | output | 2 | Token kind: 1 SETUP, 2 OUT, 3 IN |
| tok_toggle_o | output | 1 | Data toggle for the token (0 = DATA0) |
| rsp_valid_i | input | 1 | Outcome strobe from the engine |
| rsp_kind_i | input | 3 | Outcome code: 0 ACK, 1 NAK, 2 STALL, 3 timeout, 4 data |
| ep0_irq_o | output | 1 | Endpoint-0 interrupt pulse |

## Verification
The hardest case to reach from the ports is a hardware set and a software clear landing on the same clock edge. The bench gets there by holding an IN token outstanding and then driving the data outcome and a write of zero in the same cycle. The NAK halt is also hard to reach. It needs a run of NAKs with start-of-frame ticks in between, and the bench does this with an outstanding IN token that it leaves unanswered. The retry-count reset is tested by putting a NAK between two pairs of timeouts.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  typedef enum logic [1:0] {
    TOK_NONE  = 2'd0,
    TOK_SETUP = 2'd1,
    TOK_OUT   = 2'd2,
    TOK_IN    = 2'd3
  } tok_e;

  typedef enum logic [2:0] {
    RSP_ACK   = 3'd0,
    RSP_NAK   = 3'd1,
    RSP_STALL = 3'd2,
    RSP_TMO   = 3'd3,
    RSP_DATA  = 3'd4
  } rsp_e;

  typedef struct packed {
    logic ack;
    logic nak;
    logic stall;
    logic tmo;
    logic data;
  } evt_t;

  localparam int unsigned B_HALT  = 7;
  localparam int unsigned B_STAT  = 6;
  localparam int unsigned B_INREQ = 5;
  localparam int unsigned B_ERR   = 4;
  localparam int unsigned B_SETUP = 3;
  localparam int unsigned B_STALL = 2;
  localparam int unsigned B_TXRDY = 1;
  localparam int unsigned B_RXRDY = 0;
endpackage

// File: rtl/ep0_txn_seq.sv
module ep0_txn_seq
  import ep0_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_rdy_i,
  input  logic       setup_sel_i,
  input  logic       in_req_i,
  input  logic       halt_i,
  input  logic       rsp_valid_i,
  input  logic [2:0] rsp_kind_i,
  output logic       tok_req_o,
  output tok_e       tok_kind_o,
  output evt_t       evt_o
);
  logic busy_q;
  tok_e cur_q;
  logic rsp_ok;

  always_comb begin
    if (tx_rdy_i)      tok_kind_o = setup_sel_i ? TOK_SETUP : TOK_OUT;
    else if (in_req_i) tok_kind_o = TOK_IN;
    else               tok_kind_o = TOK_NONE;
  end

  assign tok_req_o = !busy_q && !halt_i && (tok_kind_o != TOK_NONE);
  assign rsp_ok    = rsp_valid_i && busy_q;

  always_comb begin
    evt_o       = '0;
    evt_o.ack   = rsp_ok && (rsp_kind_i == RSP_ACK) && (cur_q != TOK_IN);
    evt_o.nak   = rsp_ok && (rsp_kind_i == RSP_NAK);
    evt_o.stall = rsp_ok && (rsp_kind_i == RSP_STALL);
    evt_o.tmo   = rsp_ok && (rsp_kind_i == RSP_TMO);
    evt_o.data  = rsp_ok && (rsp_kind_i == RSP_DATA) && (cur_q == TOK_IN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= TOK_NONE;
    end else if (tok_req_o) begin
      busy_q <= 1'b1;
      cur_q  <= tok_kind_o;
    end else if (rsp_ok) begin
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ep0_retry_ctr.sv
module ep0_retry_ctr #(
  parameter int unsigned RETRY_MAX = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tmo_i,
  input  logic answered_i,
  input  logic restart_i,
  output logic exhaust_o
);
  localparam int unsigned CNT_W = (RETRY_MAX > 1) ? $clog2(RETRY_MAX) : 1;
  logic [CNT_W-1:0] cnt_q;

  assign exhaust_o = tmo_i && (cnt_q == CNT_W'(RETRY_MAX - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (answered_i || restart_i)  cnt_q <= '0;
    else if (exhaust_o)                cnt_q <= '0;
    else if (tmo_i)                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ep0_nak_timer.sv
module ep0_nak_timer #(
  parameter int unsigned NAK_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             nak_i,
  input  logic             other_i,
  input  logic             restart_i,
  input  logic [NAK_W-1:0] limit_i,
  output logic             expire_o
);
  logic             active_q;
  logic [NAK_W-1:0] cnt_q;
  logic [NAK_W:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + (NAK_W+1)'(1);
  assign expire_o = active_q && sof_i && (limit_i != '0) && (cnt_inc >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (other_i || restart_i || expire_o) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (nak_i) active_q <= 1'b1;
      if (active_q && sof_i) cnt_q <= cnt_inc[NAK_W-1:0];
    end
  end
endmodule

// File: rtl/ep0_csr.sv
module ep0_csr
  import ep0_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  evt_t       evt_i,
  input  logic       exhaust_i,
  input  logic       expire_i,
  output logic [7:0] rdata_o,
  output logic       tx_rdy_o,
  output logic       setup_sel_o,
  output logic       in_req_o,
  output logic       halt_o,
  output logic       toggle_o,
  output logic       irq_o,
  output logic       req_wr_o
);
  logic [7:0] r_q, r_d;
  logic       tgl_q, tgl_d;
  logic       irq_q;
  logic       drop_req;
  logic [3:0] hw_set;
  localparam int unsigned STS_IDX [4] = '{B_HALT, B_ERR, B_STALL, B_RXRDY};

  assign drop_req = evt_i.stall || exhaust_i;
  assign hw_set   = {expire_i, exhaust_i, evt_i.stall, evt_i.data};
  assign req_wr_o = wr_i && (wdata_i[B_TXRDY] || wdata_i[B_INREQ]);

  always_comb begin
    r_d = r_q;
    // status bits: write-0 clears, hardware set wins
    for (int i = 0; i < 4; i++) begin
      if (wr_i && !wdata_i[STS_IDX[i]]) r_d[STS_IDX[i]] = 1'b0;
      if (hw_set[3-i])                  r_d[STS_IDX[i]] = 1'b1;
    end
    // request bits: software write wins over hardware clear
    if (wr_i) begin
      r_d[B_TXRDY] = wdata_i[B_TXRDY];
      r_d[B_SETUP] = wdata_i[B_SETUP];
      r_d[B_INREQ] = wdata_i[B_INREQ];
      r_d[B_STAT]  = wdata_i[B_STAT];
    end else begin
      if (evt_i.ack || drop_req) begin
        r_d[B_TXRDY] = 1'b0;
        r_d[B_SETUP] = 1'b0;
      end
      if (evt_i.data || drop_req) r_d[B_INREQ] = 1'b0;
      if (evt_i.ack || evt_i.data || drop_req) r_d[B_STAT] = 1'b0;
    end
  end

  always_comb begin
    tgl_d = tgl_q;
    if (wr_i && wdata_i[B_SETUP])     tgl_d = 1'b0;
    else if (wr_i && wdata_i[B_STAT]) tgl_d = 1'b1;
    else if (evt_i.ack || evt_i.data) tgl_d = !tgl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q   <= '0;
      tgl_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      r_q   <= r_d;
      tgl_q <= tgl_d;
      irq_q <= evt_i.ack || evt_i.data || exhaust_i;
    end
  end

  assign rdata_o     = r_q;
  assign tx_rdy_o    = r_q[B_TXRDY];
  assign setup_sel_o = r_q[B_SETUP];
  assign in_req_o    = r_q[B_INREQ];
  assign halt_o      = r_q[B_HALT];
  assign toggle_o    = tgl_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/usb_ep0_host_ctrl.sv
module usb_ep0_host_ctrl
  import ep0_pkg::*;
#(
  parameter int unsigned NAK_W     = 8,
  parameter int unsigned RETRY_MAX = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic [NAK_W-1:0] nak_limit_i,
  input  logic             sof_i,
  output logic             tok_req_o,
  output logic [1:0]       tok_kind_o,
  output logic             tok_toggle_o,
  input  logic             rsp_valid_i,
  input  logic [2:0]       rsp_kind_i,
  output logic             ep0_irq_o
);
  evt_t evt;
  tok_e kind;
  logic tx_rdy, setup_sel, in_req, halt, req_wr;
  logic exhaust, expire, answered;

  assign answered   = evt.ack || evt.nak || evt.stall || evt.data;
  assign tok_kind_o = kind;

  ep0_csr u_csr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .wdata_i     (reg_wdata_i),
    .evt_i       (evt),
    .exhaust_i   (exhaust),
    .expire_i    (expire),
    .rdata_o     (reg_rdata_o),
    .tx_rdy_o    (tx_rdy),
    .setup_sel_o (setup_sel),
    .in_req_o    (in_req),
    .halt_o      (halt),
    .toggle_o    (tok_toggle_o),
    .irq_o       (ep0_irq_o),
    .req_wr_o    (req_wr)
  );

  ep0_txn_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_rdy_i    (tx_rdy),
    .setup_sel_i (setup_sel),
    .in_req_i    (in_req),
    .halt_i      (halt),
    .rsp_valid_i (rsp_valid_i),
    .rsp_kind_i  (rsp_kind_i),
    .tok_req_o   (tok_req_o),
    .tok_kind_o  (kind),
    .evt_o       (evt)
  );

  ep0_retry_ctr #(.RETRY_MAX(RETRY_MAX)) u_retry (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tmo_i      (evt.tmo),
    .answered_i (answered),
    .restart_i  (req_wr),
    .exhaust_o  (exhaust)
  );

  ep0_nak_timer #(.NAK_W(NAK_W)) u_nak (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sof_i     (sof_i),
    .nak_i     (evt.nak),
    .other_i   (evt.ack || evt.stall || evt.tmo || evt.data),
    .restart_i (req_wr),
    .limit_i   (nak_limit_i),
    .expire_o  (expire)
  );
endmodule

// File: rtl/usb_ep0_host_ctrl_chk.sv
module usb_ep0_host_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] reg_rdata_o,
  input logic       tok_req_o,
  input logic [1:0] tok_kind_o,
  input logic       tok_toggle_o,
  input logic       ep0_irq_o
);
  p_tx_kind_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_req_o && tok_kind_o != 2'd3 |-> reg_rdata_o[1]);
  p_setup_data0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_req_o && tok_kind_o == 2'd1 |-> !tok_toggle_o);
  p_status_data1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_req_o && reg_rdata_o[6] && !reg_rdata_o[3] |-> tok_toggle_o);
  p_irq_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep0_irq_o |=> !ep0_irq_o);
  p_rx_clears_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[0]) |-> !reg_rdata_o[5]);
  p_err_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[4]) |-> ep0_irq_o);
  p_halt_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7] |-> !tok_req_o);
  p_stall_drops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[2]) |-> !reg_rdata_o[1] && !reg_rdata_o[5]);
  p_single_issue_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_req_o |=> !tok_req_o);
endmodule

bind usb_ep0_host_ctrl usb_ep0_host_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_rdata_o  (reg_rdata_o),
  .tok_req_o    (tok_req_o),
  .tok_kind_o   (tok_kind_o),
  .tok_toggle_o (tok_toggle_o),
  .ep0_irq_o    (ep0_irq_o)
);

// File: tb/usb_ep0_host_ctrl_bench.sv
module usb_ep0_host_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int NAK_W = 8;
  localparam logic [2:0] ACK = 3'd0, NAK = 3'd1, STL = 3'd2, TMO = 3'd3, DAT = 3'd4;

  // {do_wr, wdata[8], kind[2], toggle, rsp[3], exp_reg[8], exp_irq}
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 8'h0A, 2'd1, 1'b0, ACK, 8'h00, 1'b1},
    {1'b1, 8'h20, 2'd3, 1'b1, DAT, 8'h01, 1'b1},
    {1'b1, 8'h20, 2'd3, 1'b0, DAT, 8'h01, 1'b1},
    {1'b1, 8'h42, 2'd2, 1'b1, ACK, 8'h00, 1'b1},
    {1'b1, 8'h02, 2'd2, 1'b0, NAK, 8'h02, 1'b0},
    {1'b0, 8'h00, 2'd2, 1'b0, ACK, 8'h00, 1'b1},
    {1'b1, 8'h60, 2'd3, 1'b1, DAT, 8'h01, 1'b1},
    {1'b1, 8'h02, 2'd2, 1'b0, STL, 8'h04, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic [7:0]       reg_wdata = '0;
  logic [7:0]       reg_rdata;
  logic [NAK_W-1:0] nak_limit = 8'd3;
  logic             sof = 1'b0;
  logic             tok_req;
  logic [1:0]       tok_kind;
  logic             tok_toggle;
  logic             rsp_valid = 1'b0;
  logic [2:0]       rsp_kind = '0;
  logic             irq;
  int               n_chk = 0;
  int               n_err = 0;

  always #(CLK_P/2) clk = !clk;

  usb_ep0_host_ctrl #(.NAK_W(NAK_W), .RETRY_MAX(3)) u_usb_ep0_host_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .nak_limit_i(nak_limit), .sof_i(sof),
    .tok_req_o(tok_req), .tok_kind_o(tok_kind), .tok_toggle_o(tok_toggle),
    .rsp_valid_i(rsp_valid), .rsp_kind_i(rsp_kind), .ep0_irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic respond(input logic [2:0] k);
    @(negedge clk); rsp_valid = 1'b1; rsp_kind = k;
    @(negedge clk); rsp_valid = 1'b0;
  endtask

  task automatic sof_tick();
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reg", reg_rdata, 8'h00);
    check("R1 tok", tok_req, 1'b0);
    check("R1 irq", irq, 1'b0);
    // R11 outcome while idle ignored
    respond(DAT);
    check("R11 idle rsp reg", reg_rdata, 8'h00);
    check("R11 idle rsp irq", irq, 1'b0);

    // vector table: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][23]) wr_reg(VEC[i][22:15]);
      check("R2 tok_req", tok_req, 1'b1);
      check("R2 kind", tok_kind, VEC[i][14:13]);
      check("R3 toggle", tok_toggle, VEC[i][12]);
      @(negedge clk);
      check("R11 one outstanding", tok_req, 1'b0);
      rsp_valid = 1'b1; rsp_kind = VEC[i][11:9];
      @(negedge clk);
      rsp_valid = 1'b0;
      check("R4 R5 R6 R9 reg", reg_rdata, VEC[i][8:1]);
      check("R4 R5 irq", irq, VEC[i][0]);
    end
    @(negedge clk);
    check("R4 irq one cycle", irq, 1'b0);

    // R10 write 1 leaves status, write 0 clears
    wr_reg(8'h04);
    check("R10 write1 keeps", reg_rdata, 8'h04);
    wr_reg(8'h00);
    check("R10 write0 clears", reg_rdata, 8'h00);

    // R3 setup select wins over status
    wr_reg(8'h4A);
    check("R3 setup wins kind", tok_kind, 2'd1);
    check("R3 setup wins toggle", tok_toggle, 1'b0);
    respond(ACK);
    check("R6 status cleared", reg_rdata, 8'h00);

    // R7 retries with NAK restarting the count
    wr_reg(8'h02);
    respond(TMO); respond(TMO);
    check("R7 retry after two", tok_req, 1'b1);
    respond(NAK);
    respond(TMO); respond(TMO);
    check("R7 nak restarts count", reg_rdata, 8'h02);
    respond(TMO);
    check("R7 error set", reg_rdata, 8'h10);
    check("R7 error irq", irq, 1'b1);
    check("R7 no token", tok_req, 1'b0);
    wr_reg(8'h00);
    check("R10 clear error", reg_rdata, 8'h00);

    // R8 NAK duration halt
    wr_reg(8'h20);
    respond(NAK);
    sof_tick(); sof_tick();
    check("R8 below limit", reg_rdata, 8'h20);
    sof_tick();
    check("R8 halt set", reg_rdata, 8'hA0);
    respond(NAK);
    check("R8 halted no token", tok_req, 1'b0);
    repeat (3) @(negedge clk);
    check("R8 stays halted", tok_req, 1'b0);
    wr_reg(8'h20);
    check("R8 resume after clear", tok_req, 1'b1);
    // R10 hardware set beats software clear in the same cycle
    @(negedge clk);
    rsp_valid = 1'b1; rsp_kind = DAT; reg_wr = 1'b1; reg_wdata = 8'h00;
    @(negedge clk);
    rsp_valid = 1'b0; reg_wr = 1'b0;
    check("R10 hw set wins", reg_rdata, 8'h01);
    check("R5 irq on data", irq, 1'b1);
    wr_reg(8'h01);
    check("R10 write1 rx keeps", reg_rdata, 8'h01);
    wr_reg(8'h00);
    check("R10 rx cleared", reg_rdata, 8'h00);

    finish_run();
  end
endmodule